// File: doc/BRIEF.md
# Serial Interrupt Host Frame Controller

This block is the host end of a single-wire, open-drain serial interrupt line. It runs a repeating cycle on the line. The cycle opens with a Start Frame, a low pulse from the host. A fixed number of three-clock data slots follows, in which devices may pull the line low to signal an interrupt. The cycle closes with a Stop Frame. Every host-driven pulse is followed by one clock in which the host drives the line high, to recover it quickly, and then one clock in which the host releases it.

The width of the Stop pulse tells the devices which mode comes next:
- **Continuous mode:** the host opens a new cycle right after the Stop turn-around clock.
- **Quiet mode:** the line stays idle until some device pulls it low for one clock. The host then takes over and completes the Start pulse to its configured width.

The level sampled in each slot is gathered during the cycle. It is presented as a status vector only once the whole cycle has finished, together with a one-clock valid pulse.

The surrounding logic sees the line as three signals:
- a drive-enable and a drive-value output, which feed an open-drain pad;
- a synchronous line-level input, which reads back the resolved wire.

A `quietSel` input chooses the mode for the cycle that follows each Stop Frame.

Top module: `sirq_host_top`

## Requirements
- R1: While reset (`rstN` low, asynchronous) is asserted, `driveEn`, `irqStatus` and `statusValid` are all 0. Reset leaves the block in continuous mode. The first clock after reset release begins a Start Frame.
- R2: A Start Frame opened by the host drives the line low (`driveEn`=1, `driveVal`=0) for exactly `START_W` clocks. It then drives high (`driveEn`=1, `driveVal`=1) for one clock, then releases (`driveEn`=0) for one clock. `START_W` is a parameter in the range 4 to 8.
- R3: After the Start turn-around there are `NUM_SLOTS` slots of three clocks each: sample, recovery, turn-around. The host keeps the line released for all of them.
- R4: After a cycle, `irqStatus[i]` is 1 exactly when the line was low in the sample clock of slot i. Bit 0 belongs to the first slot.
- R5: `irqStatus` changes only in the clock just after the Stop turn-around clock. `statusValid` is high for that one clock only.
- R6: The Stop Frame drives low for 2 clocks if `quietSel` was 1 at the clock edge that enters it, and for 3 clocks otherwise. It then drives high for one clock and releases for one clock.
- R7: After a 3-clock Stop (continuous), the next Start Frame begins in the clock right after the Stop turn-around.
- R8: After a 2-clock Stop (quiet), the host keeps the line released for as long as no device pulls it low.
- R9: In quiet idle, a one-clock low from a device makes the host drive low for `START_W`-1 further clocks, so the Start pulse totals `START_W` clocks. The normal recovery and slots follow.
- R10: Lows on the line during the slots of a cycle never start a new frame. The cycle keeps its normal timing, even when quiet mode is active.
- R11: Asserting reset in the middle of a host-driven pulse releases the line at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rstN | input | 1 | Asynchronous active-low reset |
| quietSel | input | 1 | Mode for the next cycle: 1 quiet, 0 continuous; sampled on entry to the Stop Frame |
| lineIn | input | 1 | Synchronous level of the shared line |
| driveEn | output | 1 | Host drives the line when 1 |
| driveVal | output | 1 | Level driven while `driveEn` is 1 |
| irqStatus | output | NUM_SLOTS | Slot results of the last completed cycle; 1 means the line was low |
| statusValid | output | 1 | One-clock pulse when `irqStatus` is updated |

## Verification
A wrong state or counter in the sequencer shows up on the drive pins in the same clock. Examples are a pulse that is one clock long or short, a missing high recovery clock, or a line driven during a slot. It also shows up one cycle later as a status vector that is shifted or latched too early. A mode bit that is wrong appears within two clocks of the Stop Frame: either the host restarts when it should wait, or it sits idle when it should restart. Faults in the slot sampling appear as wrong bits in `irqStatus` at the end of the cycle they corrupt.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SREC,
    ST_STA,
    ST_SLOT,
    ST_STOP,
    ST_PREC,
    ST_PTA
  } sirq_state_t;

  typedef struct packed {
    logic sampleEn;
    logic latchEn;
  } strobe_t;

endpackage

// File: rtl/sirq_host_ctrl.sv
module sirq_host_ctrl
  import sirq_pkg::*;
#(
  parameter int START_W   = 4,
  parameter int NUM_SLOTS = 21
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    quietSel,
  input  logic    lineIn,
  output logic    driveEn,
  output logic    driveVal,
  output strobe_t strb
);

  localparam int CNT_W  = $clog2(START_W) + 1;
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [CNT_W-1:0]  START_LAST = CNT_W'(START_W - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST  = SLOT_W'(NUM_SLOTS - 1);

  sirq_state_t       state;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        phase;
  logic [SLOT_W-1:0] slotIdx;
  logic              quietMode;
  logic [CNT_W-1:0]  stopLast;

  // quiet stop is two clocks (last count 1), continuous is three (last count 2)
  assign stopLast = quietMode ? CNT_W'(1) : CNT_W'(2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      phase     <= '0;
      slotIdx   <= '0;
      quietMode <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!quietMode) begin
            state <= ST_START;
            cnt   <= '0;
          end else if (!lineIn) begin
            // device already held the line low for one clock
            state <= ST_START;
            cnt   <= CNT_W'(1);
          end
        end
        ST_START: begin
          if (cnt == START_LAST) begin
            state <= ST_SREC;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_SREC: state <= ST_STA;
        ST_STA: begin
          state   <= ST_SLOT;
          phase   <= '0;
          slotIdx <= '0;
        end
        ST_SLOT: begin
          if (phase == 2'd2) begin
            phase <= '0;
            if (slotIdx == SLOT_LAST) begin
              state     <= ST_STOP;
              cnt       <= '0;
              quietMode <= quietSel;
            end else begin
              slotIdx <= slotIdx + SLOT_W'(1);
            end
          end else begin
            phase <= phase + 2'd1;
          end
        end
        ST_STOP: begin
          if (cnt == stopLast) begin
            state <= ST_PREC;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_PREC: state <= ST_PTA;
        ST_PTA: begin
          cnt   <= '0;
          state <= quietMode ? ST_IDLE : ST_START;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    driveEn       = (state == ST_START) || (state == ST_SREC) ||
                    (state == ST_STOP)  || (state == ST_PREC);
    driveVal      = (state == ST_SREC) || (state == ST_PREC);
    strb.sampleEn = (state == ST_SLOT) && (phase == 2'd0);
    strb.latchEn  = (state == ST_PTA);
  end

endmodule

// File: rtl/sirq_host_dp.sv
module sirq_host_dp
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS = 21
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lineIn,
  input  strobe_t              strb,
  output logic [NUM_SLOTS-1:0] irqStatus,
  output logic                 statusValid
);

  logic [NUM_SLOTS-1:0] shiftQ;
  logic [NUM_SLOTS-1:0] shiftD;

  // new sample enters at the top; after all slots, slot 0 sits in bit 0
  generate
    if (NUM_SLOTS == 1) begin : g_one
      assign shiftD = ~lineIn;
    end else begin : g_many
      assign shiftD = {~lineIn, shiftQ[NUM_SLOTS-1:1]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ      <= '0;
      irqStatus   <= '0;
      statusValid <= 1'b0;
    end else begin
      if (strb.sampleEn) shiftQ <= shiftD;
      if (strb.latchEn) irqStatus <= shiftQ;
      statusValid <= strb.latchEn;
    end
  end

endmodule

// File: rtl/sirq_host_top.sv
module sirq_host_top
  import sirq_pkg::*;
#(
  parameter int START_W   = 4,
  parameter int NUM_SLOTS = 21
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 quietSel,
  input  logic                 lineIn,
  output logic                 driveEn,
  output logic                 driveVal,
  output logic [NUM_SLOTS-1:0] irqStatus,
  output logic                 statusValid
);

  strobe_t strb;

  sirq_host_ctrl #(
    .START_W  (START_W),
    .NUM_SLOTS(NUM_SLOTS)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .quietSel(quietSel),
    .lineIn  (lineIn),
    .driveEn (driveEn),
    .driveVal(driveVal),
    .strb    (strb)
  );

  sirq_host_dp #(
    .NUM_SLOTS(NUM_SLOTS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .lineIn     (lineIn),
    .strb       (strb),
    .irqStatus  (irqStatus),
    .statusValid(statusValid)
  );

endmodule

// File: rtl/sirq_host_chk.sv
module sirq_host_chk
  import sirq_pkg::*;
#(
  parameter int START_W   = 4,
  parameter int NUM_SLOTS = 21
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 driveEn,
  input logic                 driveVal,
  input logic [NUM_SLOTS-1:0] irqStatus,
  input logic                 statusValid,
  input strobe_t              strb
);

  localparam int RUN_W = $clog2(START_W + 2);

  logic [RUN_W-1:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowRun <= '0;
    else if (driveEn && !driveVal) lowRun <= lowRun + RUN_W'(1);
    else lowRun <= '0;
  end

  // R2
  recovery_after_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && driveVal) |-> $past(driveEn && !driveVal));

  // R6
  release_after_recovery_chk: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && driveVal) |=> !driveEn);

  // R5
  status_change_flagged_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqStatus != $past(irqStatus)) |-> statusValid);

  // R5
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |=> !statusValid);

  // R3
  sample_while_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleEn |-> !driveEn);

  // R9
  low_run_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && !driveVal) |-> (int'(lowRun) < START_W));

endmodule

bind sirq_host_top sirq_host_chk #(
  .START_W  (START_W),
  .NUM_SLOTS(NUM_SLOTS)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .driveEn    (driveEn),
  .driveVal   (driveVal),
  .irqStatus  (irqStatus),
  .statusValid(statusValid),
  .strb       (strb)
);

// File: tb/sirq_host_top_tb_top.sv
module sirq_host_top_tb_top;

  localparam int START_W = 5;
  localparam int NSLOT   = 21;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rstN = 1'b0;
  logic             quietSel = 1'b0;
  logic             devLow = 1'b0;
  wire              lineIn;
  logic             driveEn;
  logic             driveVal;
  logic [NSLOT-1:0] irqStatus;
  logic             statusValid;

  int total = 0;
  int bad = 0;
  bit modeQuiet = 1'b0;
  logic [NSLOT-1:0] expStatus = '0;

  // resolved open-drain wire with pull-up
  assign lineIn = driveEn ? driveVal : ~devLow;

  sirq_host_top #(.START_W(START_W), .NUM_SLOTS(NSLOT)) dut_i (
    .clk(clk), .rstN(rstN), .quietSel(quietSel), .lineIn(lineIn),
    .driveEn(driveEn), .driveVal(driveVal),
    .irqStatus(irqStatus), .statusValid(statusValid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int stopWidth(input bit q);
    return q ? 2 : 3;
  endfunction

  // entry: at a negedge where the first host-driven Start clock is visible
  task automatic doCycle(input logic [NSLOT-1:0] mask, input bit qNext,
                         input int startLen, input string startReq);
    int good = 0;
    int rel = 0;
    int low = 0;
    bit prevQuiet = modeQuiet;
    quietSel = qNext;
    for (int k = 0; k < startLen; k++) begin
      if (driveEn && !driveVal) good++;
      @(negedge clk);
    end
    chk(good == startLen, startReq, "start low clocks", good, startLen);
    chk(driveEn && driveVal, "R2", "start recovery", {driveEn, driveVal}, 3);
    @(negedge clk);
    chk(!driveEn, "R2", "start turnaround", driveEn, 0);
    @(negedge clk);
    for (int i = 0; i < NSLOT; i++) begin
      for (int p = 0; p < 3; p++) begin
        if (!driveEn) rel++;
        devLow = (p == 0) && mask[i];
        @(negedge clk);
        devLow = 1'b0;
      end
    end
    chk(rel == 3 * NSLOT, "R3", "released slot clocks", rel, 3 * NSLOT);
    if (prevQuiet && mask != '0)
      chk(rel == 3 * NSLOT, "R10", "slot lows in quiet mode", rel, 3 * NSLOT);
    while (driveEn && !driveVal && low < 6) begin
      low++;
      @(negedge clk);
    end
    chk(low == stopWidth(qNext), "R6", "stop low clocks", low, stopWidth(qNext));
    chk(driveEn && driveVal, "R6", "stop recovery", {driveEn, driveVal}, 3);
    @(negedge clk);
    chk(!driveEn, "R6", "stop turnaround", driveEn, 0);
    chk(!statusValid && irqStatus == expStatus, "R5", "status held before end",
        irqStatus, expStatus);
    @(negedge clk);
    chk(irqStatus == mask, "R4", "slot status", irqStatus, mask);
    chk(statusValid, "R5", "valid pulse", statusValid, 1);
    expStatus = mask;
    if (!qNext)
      chk(driveEn && !driveVal, "R7", "immediate restart", {driveEn, driveVal}, 2);
    else
      chk(!driveEn, "R8", "idle after quiet stop", driveEn, 0);
    modeQuiet = qNext;
  endtask

  // entry: quiet idle visible; leaves first host Start clock visible
  task automatic quietRequest(input int gap);
    bit ok = 1'b1;
    for (int g = 0; g < gap; g++) begin
      if (driveEn) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok && !driveEn, "R8", "line released in quiet idle", driveEn, 0);
    devLow = 1'b1;
    @(negedge clk);
    devLow = 1'b0;
  endtask

  task automatic nextCycle(input logic [NSLOT-1:0] mask, input bit q, input int gap);
    if (modeQuiet) begin
      quietRequest(gap);
      doCycle(mask, q, START_W - 1, "R9");
    end else begin
      doCycle(mask, q, START_W, "R2");
    end
  endtask

  initial begin
    void'($urandom(32'h1d5e_0c4a));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!driveEn, "R1", "released in reset", driveEn, 0);
    chk(irqStatus == '0 && !statusValid, "R1", "status cleared in reset", irqStatus, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(driveEn && !driveVal, "R1", "start right after reset", {driveEn, driveVal}, 2);

    nextCycle('0, 1'b0, 0);
    nextCycle('1, 1'b0, 0);
    nextCycle(21'h0A_AAAA, 1'b1, 0);
    nextCycle(21'h10_0001, 1'b1, 0);
    nextCycle(21'h05_5555, 1'b1, 15);
    nextCycle(21'h00_0100, 1'b0, 3);

    for (int n = 0; n < 25; n++) begin
      logic [NSLOT-1:0] m;
      m = NSLOT'($urandom);
      nextCycle(m, 1'($urandom % 2), int'($urandom % 8));
    end

    // R11: reset during a host-driven pulse
    if (modeQuiet) quietRequest(2);
    chk(driveEn && !driveVal, "R11", "pulse before reset", {driveEn, driveVal}, 2);
    #1 rstN = 1'b0;
    #1;
    chk(!driveEn, "R11", "async release", driveEn, 0);
    chk(irqStatus == '0, "R1", "status cleared by reset", irqStatus, 0);
    @(negedge clk);
    rstN = 1'b1;
    modeQuiet = 1'b0;
    expStatus = '0;
    @(negedge clk);
    chk(driveEn && !driveVal, "R1", "start after second reset", {driveEn, driveVal}, 2);
    nextCycle(21'h1F_0F0F, 1'b0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule